// File: doc/BRIEF.md
# Floating-Point Control Word and Deferred Exception Unit

This unit owns the 16-bit floating-point control word and decides when a pending floating-point exception is signalled to the pipeline. Each cycle the execute stage may present one floating-point instruction. The instruction can be a control-word load, recognised from its opcode byte and ModRM reg field. It can be a clear-exceptions request, or any other floating-point instruction marked as either a waiting or a no-wait form. The datapath reports new exception flags through a set vector. The unit keeps these flags as sticky bits until a clear request empties them.

A load writes the new word without raising anything, even when that word unmasks a flag that is already set. The unmasked exception is held back instead. It fires on the next waiting instruction, and no-wait instructions pass it by. If either system control bit for emulation or task switching is set, the load does not execute: the unit raises a device-not-available fault and keeps the old word.

Top module: `fpu_cw_defer`

## Requirements
- R1: After a synchronous reset, `cw` reads 16'h037F (all six exception masks set), the stored exception flags are empty, and `fp_exc` stays low.
- R2: An executing instruction whose opcode byte is 8'hD9, whose ModRM reg field is 3'd5 and whose `ex_clear` is low is a load. When neither `sys_ctl[2]` nor `sys_ctl[3]` is set, a load replaces all 16 bits of `cw` with `ld_data` from the next cycle. Any other opcode/reg pair leaves `cw` unchanged.
- R3: A load with `sys_ctl[2]` or `sys_ctl[3]` at 1 drives `nm_fault` high in the same cycle and leaves `cw` unchanged. `nm_fault` is low in every other cycle.
- R4: A load never drives `fp_exc`, including when the loaded word unmasks a stored flag.
- R5: A waiting instruction (`ex_valid` high, `ex_nowait` low, not a load, not a clear) drives `fp_exc` high in that same cycle exactly when `flags & ~cw[5:0]` is nonzero. Bit i of `cw` masks flag bit i.
- R6: A no-wait instruction never drives `fp_exc`. The pending exception stays for the next waiting instruction.
- R7: A clear request (`ex_valid` and `ex_clear` high) empties all stored flags from the next cycle, so a later waiting instruction raises nothing. A clear wins over a flag set in the same cycle.
- R8: Bits of `flag_set` are OR-ed into the stored flags. Raising `fp_exc` does not clear them, so each further waiting instruction signals again.
- R9: A stored flag whose mask bit in `cw` is 1 never causes `fp_exc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ex_valid | input | 1 | An instruction executes this cycle |
| ex_opcode | input | 8 | Opcode byte of the executing instruction |
| ex_modrm_reg | input | 3 | ModRM reg field of the executing instruction |
| ex_nowait | input | 1 | Executing instruction is a no-wait form |
| ex_clear | input | 1 | Executing instruction is a clear-exceptions request |
| ld_data | input | 16 | Operand for a control-word load |
| flag_set | input | 6 | Exception flags raised by the datapath this cycle |
| sys_ctl | input | 4 | System control bits; bit 2 emulate, bit 3 task switched |
| cw | output | 16 | Current control word |
| nm_fault | output | 1 | Device-not-available fault for a blocked load |
| fp_exc | output | 1 | Deferred floating-point exception, same cycle as the waiting instruction |

## Verification
The bench builds the unit with its default parameters: a 16-bit word, six exception bits, reset word 16'h037F and the load recognised at 8'hD9 with reg 5. With these values the random loads often hit unmasked flags. Near-miss opcodes and reg fields show that decoding is exact, and the two system-control bit positions are driven both alone and together. Directed sequences cover the corner cases: a load that unmasks a set flag, a no-wait instruction followed by a waiting one, and a clear and a flag set in the same cycle.

// File: rtl/fcw_pkg.sv
package fcw_pkg;
  typedef struct packed {
    logic ld_ok;    // load commits
    logic nm;       // load blocked by system control
    logic clr;      // clear exceptions
    logic wait_fp;  // waiting, non-load, non-clear instruction
  } fcw_dec_t;
endpackage

// File: rtl/fcw_decode.sv
module fcw_decode
  import fcw_pkg::*;
#(
  parameter int          SYS_W   = 4,
  parameter int          EM_BIT  = 2,
  parameter int          TS_BIT  = 3,
  parameter logic [7:0]  LD_OPC  = 8'hD9,
  parameter logic [2:0]  LD_REG  = 3'd5
) (
  input  logic             ex_valid,
  input  logic [7:0]       ex_opcode,
  input  logic [2:0]       ex_modrm_reg,
  input  logic             ex_nowait,
  input  logic             ex_clear,
  input  logic [SYS_W-1:0] sys_ctl,
  output fcw_dec_t         dec
);
  logic is_ld;
  logic blocked;

  always_comb begin
    is_ld       = ex_valid && !ex_clear && (ex_opcode == LD_OPC) && (ex_modrm_reg == LD_REG);
    blocked     = sys_ctl[EM_BIT] | sys_ctl[TS_BIT];
    dec.nm      = is_ld && blocked;
    dec.ld_ok   = is_ld && !blocked;
    dec.clr     = ex_valid && ex_clear;
    dec.wait_fp = ex_valid && !ex_clear && !is_ld && !ex_nowait;
  end
endmodule

// File: rtl/fcw_reg.sv
module fcw_reg #(
  parameter int              CW_W     = 16,
  parameter logic [CW_W-1:0] RESET_CW = 16'h037F
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld_ok,
  input  logic            nm,
  input  logic [CW_W-1:0] ld_data,
  output logic [CW_W-1:0] cw_q
);
  always_ff @(posedge clk) begin
    if (rst)        cw_q <= RESET_CW;
    else if (ld_ok) cw_q <= ld_data;
  end

  // R2: a committed load shows its operand in the next cycle
  p_load_value_r2: assert property (@(posedge clk) disable iff (rst)
    ld_ok |=> cw_q == $past(ld_data));
  // R3: a blocked load leaves the word untouched
  p_blocked_hold_r3: assert property (@(posedge clk) disable iff (rst)
    nm |=> cw_q == $past(cw_q));
endmodule

// File: rtl/fcw_flags.sv
module fcw_flags #(
  parameter int NEXC = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic [NEXC-1:0] flag_set,
  input  logic [NEXC-1:0] masks,
  output logic            pending
);
  logic [NEXC-1:0] flags_q;
  logic [NEXC-1:0] live;

  always_ff @(posedge clk) begin
    if (rst || clr) flags_q <= '0;
    else            flags_q <= flags_q | flag_set;
  end

  for (genvar i = 0; i < NEXC; i++) begin : g_live
    assign live[i] = flags_q[i] & ~masks[i];
  end

  assign pending = |live;

  // R7: a clear empties every flag, even against a same-cycle set
  p_clear_empties_r7: assert property (@(posedge clk) disable iff (rst)
    clr |=> flags_q == '0);
  // R8: without a clear, flags are sticky
  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (flags_q & $past(flags_q)) == $past(flags_q));
endmodule

// File: rtl/fpu_cw_defer.sv
module fpu_cw_defer
  import fcw_pkg::*;
#(
  parameter int              CW_W     = 16,
  parameter int              NEXC     = 6,
  parameter int              SYS_W    = 4,
  parameter int              EM_BIT   = 2,
  parameter int              TS_BIT   = 3,
  parameter logic [CW_W-1:0] RESET_CW = 16'h037F,
  parameter logic [7:0]      LD_OPC   = 8'hD9,
  parameter logic [2:0]      LD_REG   = 3'd5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ex_valid,
  input  logic [7:0]       ex_opcode,
  input  logic [2:0]       ex_modrm_reg,
  input  logic             ex_nowait,
  input  logic             ex_clear,
  input  logic [CW_W-1:0]  ld_data,
  input  logic [NEXC-1:0]  flag_set,
  input  logic [SYS_W-1:0] sys_ctl,
  output logic [CW_W-1:0]  cw,
  output logic             nm_fault,
  output logic             fp_exc
);
  fcw_dec_t dec;
  logic     pending;

  fcw_decode #(
    .SYS_W(SYS_W), .EM_BIT(EM_BIT), .TS_BIT(TS_BIT),
    .LD_OPC(LD_OPC), .LD_REG(LD_REG)
  ) u_dec (
    .ex_valid(ex_valid), .ex_opcode(ex_opcode), .ex_modrm_reg(ex_modrm_reg),
    .ex_nowait(ex_nowait), .ex_clear(ex_clear), .sys_ctl(sys_ctl), .dec(dec)
  );

  fcw_reg #(.CW_W(CW_W), .RESET_CW(RESET_CW)) u_reg (
    .clk(clk), .rst(rst), .ld_ok(dec.ld_ok), .nm(dec.nm),
    .ld_data(ld_data), .cw_q(cw)
  );

  fcw_flags #(.NEXC(NEXC)) u_flags (
    .clk(clk), .rst(rst), .clr(dec.clr), .flag_set(flag_set),
    .masks(cw[NEXC-1:0]), .pending(pending)
  );

  assign nm_fault = dec.nm;
  assign fp_exc   = dec.wait_fp && pending;

  // R6: no-wait forms never signal
  p_nowait_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (ex_valid && ex_nowait) |-> !fp_exc);
  // R4: a load never signals, whatever it unmasks
  p_load_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (ex_valid && !ex_clear && ex_opcode == LD_OPC && ex_modrm_reg == LD_REG) |-> !fp_exc);
  // R5: the pulse only accompanies an executing instruction
  p_with_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    fp_exc |-> (ex_valid && !ex_clear));
  // R3: the fault only accompanies an executing instruction
  p_fault_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    nm_fault |-> (ex_valid && !fp_exc));
endmodule

// File: tb/fpu_cw_defer_tb.sv
module fpu_cw_defer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        ex_valid;
  logic [7:0]  ex_opcode;
  logic [2:0]  ex_modrm_reg;
  logic        ex_nowait;
  logic        ex_clear;
  logic [15:0] ld_data;
  logic [5:0]  flag_set;
  logic [3:0]  sys_ctl;
  logic [15:0] cw;
  logic        nm_fault;
  logic        fp_exc;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [15:0] cw_m;
  logic [5:0]  flags_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpu_cw_defer u_dut (
    .clk(clk), .rst(rst), .ex_valid(ex_valid), .ex_opcode(ex_opcode),
    .ex_modrm_reg(ex_modrm_reg), .ex_nowait(ex_nowait), .ex_clear(ex_clear),
    .ld_data(ld_data), .flag_set(flag_set), .sys_ctl(sys_ctl),
    .cw(cw), .nm_fault(nm_fault), .fp_exc(fp_exc)
  );

  function automatic bit is_load(bit v, bit c, logic [7:0] o, logic [2:0] r);
    return v && !c && o == 8'hD9 && r == 3'd5;
  endfunction

  function automatic bit exp_exc(bit v, bit c, bit nw, logic [7:0] o, logic [2:0] r,
                                 logic [15:0] cwv, logic [5:0] fl);
    return v && !c && !is_load(v, c, o, r) && !nw && (|(fl & ~cwv[5:0]));
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(bit v, logic [7:0] o, logic [2:0] r, bit nw, bit c,
                      logic [15:0] d, logic [5:0] fs, logic [3:0] sc);
    bit ld, nm, ex;
    @(negedge clk);
    check("R2 cw", cw, cw_m);
    ex_valid = v; ex_opcode = o; ex_modrm_reg = r; ex_nowait = nw;
    ex_clear = c; ld_data = d; flag_set = fs; sys_ctl = sc;
    #1;
    ld = is_load(v, c, o, r);
    nm = ld && (sc[2] || sc[3]);
    ex = exp_exc(v, c, nw, o, r, cw_m, flags_m);
    check("R3 nm_fault", {15'b0, nm_fault}, {15'b0, nm});
    if (ld)      check("R4 fp_exc on load", {15'b0, fp_exc}, {15'b0, ex});
    else if (nw) check("R6 fp_exc on no-wait", {15'b0, fp_exc}, {15'b0, ex});
    else if (!(|(flags_m & ~cw_m[5:0])) && (|flags_m))
                 check("R9 masked flags", {15'b0, fp_exc}, {15'b0, ex});
    else         check("R5 fp_exc on waiting", {15'b0, fp_exc}, {15'b0, ex});
    @(posedge clk);
    if (ld && !nm) cw_m = d;
    if (v && c) flags_m = '0;
    else        flags_m = flags_m | fs;
  endtask

  initial begin
    rst = 1'b1; ex_valid = 0; ex_opcode = 0; ex_modrm_reg = 0; ex_nowait = 0;
    ex_clear = 0; ld_data = 0; flag_set = 0; sys_ctl = 0;
    cw_m = 16'h037F; flags_m = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset cw", cw, 16'h037F);
    // R1: a waiting op after reset raises nothing
    step(1, 8'hDE, 3'd0, 0, 0, 16'h0, 6'h0, 4'h0);
    // R9: flag set but masked
    step(0, 8'h00, 3'd0, 0, 0, 16'h0, 6'h01, 4'h0);
    step(1, 8'hD8, 3'd1, 0, 0, 16'h0, 6'h0, 4'h0);
    // R4: load unmasking everything stays silent
    step(1, 8'hD9, 3'd5, 0, 0, 16'h0000, 6'h0, 4'h0);
    // R6: no-wait passes the pending exception by
    step(1, 8'hDB, 3'd2, 1, 0, 16'h0, 6'h0, 4'h0);
    // R5, R8: waiting op fires, and fires again
    step(1, 8'hD8, 3'd0, 0, 0, 16'h0, 6'h0, 4'h0);
    step(1, 8'hDC, 3'd3, 0, 0, 16'h0, 6'h0, 4'h0);
    // R7: clear, then nothing fires
    step(1, 8'hDB, 3'd4, 1, 1, 16'h0, 6'h0, 4'h0);
    step(1, 8'hD8, 3'd0, 0, 0, 16'h0, 6'h0, 4'h0);
    // R7: clear beats same-cycle set
    step(1, 8'hDB, 3'd4, 1, 1, 16'h0, 6'h20, 4'h0);
    step(1, 8'hD8, 3'd0, 0, 0, 16'h0, 6'h0, 4'h0);
    // R3: blocked loads keep the word
    step(1, 8'hD9, 3'd5, 0, 0, 16'hFFFF, 6'h0, 4'h4);
    step(1, 8'hD9, 3'd5, 0, 0, 16'hFFFF, 6'h0, 4'h8);
    step(1, 8'hD9, 3'd5, 0, 0, 16'hFFFF, 6'h0, 4'hC);
    // R2: near-miss decodes do not load
    step(1, 8'hD9, 3'd4, 0, 0, 16'h1234, 6'h0, 4'h0);
    step(1, 8'hD8, 3'd5, 0, 0, 16'h1234, 6'h0, 4'h0);
    step(1, 8'hD9, 3'd5, 0, 0, 16'hA5C3, 6'h0, 4'h3);
    step(0, 8'h00, 3'd0, 0, 0, 16'h0, 6'h0, 4'h0);
    void'($urandom(32'd20240611));
    for (int i = 0; i < 3000; i++) begin
      bit v, nw, c;
      logic [7:0] o;
      logic [2:0] r;
      logic [15:0] d;
      logic [5:0] fs;
      logic [3:0] sc;
      int k;
      v  = ($urandom % 10) < 8;
      k  = $urandom % 20;
      c  = (k < 2);
      nw = ($urandom % 3) == 0;
      if (k < 8)       begin o = 8'hD9; r = 3'd5; end
      else if (k < 10) begin o = ($urandom % 2) ? 8'hD9 : 8'hD8; r = (o == 8'hD9) ? 3'd4 : 3'd5; end
      else             begin o = 8'hD8 + 8'($urandom % 8); r = 3'($urandom); end
      d  = 16'($urandom);
      fs = (($urandom % 4) == 0) ? 6'(1 << ($urandom % 6)) : 6'h0;
      sc = (($urandom % 5) == 0) ? 4'($urandom) : 4'h0;
      step(v, o, r, nw, c, d, fs, sc);
    end
    @(negedge clk);
    check("R2 final cw", cw, cw_m);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule